// File: doc/BRIEF.md
# Menu-Indexed SPI Flash Command Sequencer

This block runs a single serial-flash transaction per request. Software first sets up an eight-slot table of allowed opcodes and a two-bit kind for each slot. The kind tells the block whether the command has an address phase and whether it reads or writes. Software also loads two prefix opcodes, a 24-bit flash address and a 64-byte data buffer. It then writes a control word that carries a slot number, a byte count, a data-phase enable and a start bit. Software never sends an opcode directly. It can only pick one of the table slots.

Once started, the block drives an SPI mode-0 link, MSB first. In atomic mode it first sends one prefix opcode as a one-byte chip-select frame of its own. After that, the main command goes out in a new frame: the opcode, then three address bytes for addressed kinds, then the data bytes. Write kinds shift the data bytes out of the buffer. Read kinds capture the received bytes into the buffer. When the transfer is over, a status word reports completion, or an error if a start came in while the engine was busy. Completion and error are cleared by writing ones to them.

Top module: `spi_menu_engine`

Register word indices on `reg_addr`: 0–15 data buffer, 16 flash address, 17 control, 18 status, 19 opcode slots 0–3, 20 opcode slots 4–7, 21 slot kinds, 22 prefixes.

## Requirements
- R1: The opcode sent is byte (slot mod 4) of word 19 (slots 0–3) or word 20 (slots 4–7), least significant byte first. The slot number is control bits [6:4]. The kind of slot n is bits [2n+1:2n] of word 21, coded as 0 = read without address, 1 = write without address, 2 = read with address, 3 = write with address.
- R2: For addressed kinds, three address bytes follow the opcode, most significant byte first. Only bits [23:0] of word 16 are stored, read back and shifted out.
- R3: Buffer byte k is bits [8*(k%4)+7 : 8*(k%4)] of buffer word k/4. A write kind sends bytes 0 to count-1 in that order.
- R4: A read kind sends zero bytes during the data phase and stores received byte i into buffer byte i. The stored bytes can be read back once done is set.
- R5: The byte count is control bits [13:8] plus one, so it runs from 1 to 64. When control bit 14 is 0, no data bytes are transferred, whatever the count field holds.
- R6: When control bit 2 (atomic) is set, a one-byte frame holding the prefix is sent first. Control bit 3 picks prefix bits [7:0] when 0 and prefix bits [15:8] when 1. Chip select goes high between that frame and the main command frame.
- R7: Writing control with bit 1 set while idle sets status bit 0 (busy) at the next clock. Busy clears on the same edge that sets status bit 2 (done).
- R8: Writing a 1 to status bit 2 clears done, and writing a 1 to status bit 3 clears error. Writing a 0 to either bit leaves it as it is.
- R9: A start written while busy launches nothing and sets status bit 3 (error). The running transfer completes unchanged.
- R10: The link runs in mode 0: SCK is low whenever chip select is high, bits change while SCK is low, and bits are sampled on the rising edge. Chip select stays high for at least two SCK periods between frames.
- R11: After reset, status reads 0, chip select is high and SCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench goes after the data-phase gate with a large count field and the phase enable off. A design that trusted the count would clock out extra bytes after the address. It checks the prefix select with both prefix values, because a swapped select would send the other prefix in the lone first frame. A start issued while busy must leave the frame log with one transfer only; a design that restarted would emit a second opcode frame. A full 64-byte read checks that the last received byte lands in the top lane of the last buffer word, which catches off-by-one errors in the count or the byte lanes. A monitor also measures every chip-select gap and SCK level, so a short gap or SCK left high at a frame edge gets reported.

// File: rtl/spi_menu_pkg.sv
package spi_menu_pkg;

  localparam logic [4:0] RA_FADDR   = 5'd16;
  localparam logic [4:0] RA_CTRL    = 5'd17;
  localparam logic [4:0] RA_STAT    = 5'd18;
  localparam logic [4:0] RA_MENU_LO = 5'd19;
  localparam logic [4:0] RA_MENU_HI = 5'd20;
  localparam logic [4:0] RA_KINDS   = 5'd21;
  localparam logic [4:0] RA_PREFIX  = 5'd22;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_GAP1, ST_OPC, ST_ADR, ST_DAT, ST_GAP2
  } seq_state_t;

  typedef struct packed {
    logic [2:0] slot;
    logic       atomic;
    logic       psel;
    logic       dph;
    logic [5:0] cnt_m1;
  } ctl_t;

  function automatic ctl_t decode_ctl(input logic [15:0] w);
    ctl_t c;
    c.slot   = w[6:4];
    c.atomic = w[2];
    c.psel   = w[3];
    c.dph    = w[14];
    c.cnt_m1 = w[13:8];
    return c;
  endfunction

  function automatic logic [7:0] menu_pick(input logic [63:0] m, input logic [2:0] i);
    return m[{i, 3'b000} +: 8];
  endfunction

  function automatic logic [1:0] kind_pick(input logic [15:0] t, input logic [2:0] i);
    return t[{i, 1'b0} +: 2];
  endfunction

  function automatic logic [7:0] addr_byte(input logic [23:0] a, input logic [1:0] n);
    case (n)
      2'd0:    return a[23:16];
      2'd1:    return a[15:8];
      default: return a[7:0];
    endcase
  endfunction

endpackage

// File: rtl/spi_menu_regs.sv
module spi_menu_regs
  import spi_menu_pkg::*;
#(
  parameter int BUF_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        busy,
  input  logic        done_flag,
  input  logic        err_flag,
  output logic [23:0] faddr,
  output logic [63:0] menu,
  output logic [15:0] kinds,
  output logic [15:0] prefix,
  output logic        go_wr,
  output logic [15:0] ctl_word,
  output logic        clr_done,
  output logic        clr_err,
  input  logic [$clog2(BUF_BYTES)-1:0] seq_idx,
  input  logic        seq_we,
  input  logic [7:0]  seq_wbyte,
  output logic [7:0]  seq_rbyte
);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int IW    = $clog2(BUF_BYTES);
  localparam int WIW   = $clog2(WORDS);

  logic [31:0] buf_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) buf_q[i] <= '0;
      faddr  <= '0;
      menu   <= '0;
      kinds  <= '0;
      prefix <= '0;
    end else begin
      if (seq_we) buf_q[seq_idx[IW-1:2]][{seq_idx[1:0], 3'b000} +: 8] <= seq_wbyte;
      if (we) begin
        if (int'(addr) < WORDS) buf_q[addr[WIW-1:0]] <= wdata;
        case (addr)
          RA_FADDR:   faddr         <= wdata[23:0];
          RA_MENU_LO: menu[31:0]    <= wdata;
          RA_MENU_HI: menu[63:32]   <= wdata;
          RA_KINDS:   kinds         <= wdata[15:0];
          RA_PREFIX:  prefix        <= wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  assign seq_rbyte = buf_q[seq_idx[IW-1:2]][{seq_idx[1:0], 3'b000} +: 8];
  assign go_wr     = we && (addr == RA_CTRL) && wdata[1];
  assign ctl_word  = wdata[15:0];
  assign clr_done  = we && (addr == RA_STAT) && wdata[2];
  assign clr_err   = we && (addr == RA_STAT) && wdata[3];

  always_comb begin
    rdata = '0;
    if (int'(addr) < WORDS) rdata = buf_q[addr[WIW-1:0]];
    else begin
      case (addr)
        RA_FADDR:   rdata = {8'h00, faddr};
        RA_STAT:    rdata = {28'h0, err_flag, done_flag, 1'b0, busy};
        RA_MENU_LO: rdata = menu[31:0];
        RA_MENU_HI: rdata = menu[63:32];
        RA_KINDS:   rdata = {16'h0, kinds};
        RA_PREFIX:  rdata = {16'h0, prefix};
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int DIV_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int CW = $clog2(DIV_HALF + 1);

  logic          active;
  logic [CW-1:0] dcnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          half_tick;

  assign half_tick = (dcnt == CW'(DIV_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; dcnt <= '0; bitn <= '0; sh <= '0;
      sck <= 1'b0; mosi <= 1'b0; done <= 1'b0; rx <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        sh     <= tx;
        mosi   <= tx[7];
        bitn   <= '0;
        dcnt   <= '0;
      end else if (active) begin
        if (half_tick) begin
          dcnt <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              mosi <= sh[6];
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          dcnt <= dcnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_menu_seq.sv
module spi_menu_seq
  import spi_menu_pkg::*;
#(
  parameter int DIV_HALF  = 2,
  parameter int BUF_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go_wr,
  input  logic [15:0] ctl_word,
  input  logic [63:0] menu,
  input  logic [15:0] kinds,
  input  logic [15:0] prefix,
  input  logic [23:0] faddr,
  input  logic        clr_done,
  input  logic        clr_err,
  input  logic [7:0]  buf_rbyte,
  output logic [$clog2(BUF_BYTES)-1:0] buf_idx,
  output logic        buf_we,
  output logic [7:0]  buf_wbyte,
  output logic        sh_start,
  output logic [7:0]  sh_tx,
  input  logic        sh_done,
  input  logic [7:0]  sh_rx,
  output logic        cs_n,
  output logic        busy,
  output logic        done_flag,
  output logic        err_flag,
  output logic        cyc_finish
);
  localparam int GAP = 4 * DIV_HALF;
  localparam int GW  = $clog2(GAP + 1);
  localparam int IW  = $clog2(BUF_BYTES);

  seq_state_t    state;
  ctl_t          c;
  logic [1:0]    kind;
  logic [6:0]    bcnt;
  logic [GW-1:0] gcnt;
  logic          issue;
  logic          gap_end, last_data;

  assign gap_end    = (gcnt == GW'(GAP - 1));
  assign last_data  = (bcnt[5:0] == c.cnt_m1);
  assign cyc_finish = (state == ST_GAP2) && gap_end;
  assign cs_n       = !(state inside {ST_PRE, ST_OPC, ST_ADR, ST_DAT});
  assign sh_start   = issue;
  assign buf_idx    = bcnt[IW-1:0];
  assign buf_we     = (state == ST_DAT) && sh_done && !kind[0];
  assign buf_wbyte  = sh_rx;

  always_comb begin
    case (state)
      ST_PRE:  sh_tx = c.psel ? prefix[15:8] : prefix[7:0];
      ST_OPC:  sh_tx = menu_pick(menu, c.slot);
      ST_ADR:  sh_tx = addr_byte(faddr, bcnt[1:0]);
      ST_DAT:  sh_tx = kind[0] ? buf_rbyte : 8'h00;
      default: sh_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; c <= '0; kind <= '0; bcnt <= '0; gcnt <= '0;
      issue <= 1'b0; busy <= 1'b0; done_flag <= 1'b0; err_flag <= 1'b0;
    end else begin
      issue <= 1'b0;
      if (clr_done) done_flag <= 1'b0;
      if (clr_err)  err_flag  <= 1'b0;
      if (go_wr) begin
        if (busy) err_flag <= 1'b1;
        else begin
          busy  <= 1'b1;
          c     <= decode_ctl(ctl_word);
          kind  <= kind_pick(kinds, ctl_word[6:4]);
          bcnt  <= '0;
          issue <= 1'b1;
          state <= ctl_word[2] ? ST_PRE : ST_OPC;
        end
      end
      case (state)
        ST_PRE: if (sh_done) begin state <= ST_GAP1; gcnt <= '0; end
        ST_GAP1:
          if (gap_end) begin state <= ST_OPC; issue <= 1'b1; end
          else gcnt <= gcnt + GW'(1);
        ST_OPC:
          if (sh_done) begin
            bcnt <= '0;
            if (kind[1])    begin state <= ST_ADR; issue <= 1'b1; end
            else if (c.dph) begin state <= ST_DAT; issue <= 1'b1; end
            else            begin state <= ST_GAP2; gcnt <= '0; end
          end
        ST_ADR:
          if (sh_done) begin
            if (bcnt == 7'd2) begin
              bcnt <= '0;
              if (c.dph) begin state <= ST_DAT; issue <= 1'b1; end
              else       begin state <= ST_GAP2; gcnt <= '0; end
            end else begin
              bcnt <= bcnt + 7'd1; issue <= 1'b1;
            end
          end
        ST_DAT:
          if (sh_done) begin
            if (last_data) begin state <= ST_GAP2; gcnt <= '0; end
            else begin bcnt <= bcnt + 7'd1; issue <= 1'b1; end
          end
        ST_GAP2:
          if (gap_end) begin state <= ST_IDLE; busy <= 1'b0; done_flag <= 1'b1; end
          else gcnt <= gcnt + GW'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_menu_engine.sv
module spi_menu_engine #(
  parameter int DIV_HALF  = 2,
  parameter int BUF_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int IW = $clog2(BUF_BYTES);

  logic [23:0] faddr;
  logic [63:0] menu;
  logic [15:0] kinds, prefix, ctl_word;
  logic        go_evt, clr_done, clr_err;
  logic        busy_w, done_w, err_w, cyc_finish;
  logic [IW-1:0] buf_idx;
  logic        buf_we, sh_start, sh_done;
  logic [7:0]  buf_wbyte, buf_rbyte, sh_tx, sh_rx;

  spi_menu_regs #(.BUF_BYTES(BUF_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy_w), .done_flag(done_w), .err_flag(err_w),
    .faddr(faddr), .menu(menu), .kinds(kinds), .prefix(prefix),
    .go_wr(go_evt), .ctl_word(ctl_word), .clr_done(clr_done), .clr_err(clr_err),
    .seq_idx(buf_idx), .seq_we(buf_we), .seq_wbyte(buf_wbyte), .seq_rbyte(buf_rbyte)
  );

  spi_menu_seq #(.DIV_HALF(DIV_HALF), .BUF_BYTES(BUF_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_wr(go_evt), .ctl_word(ctl_word), .menu(menu),
    .kinds(kinds), .prefix(prefix), .faddr(faddr), .clr_done(clr_done),
    .clr_err(clr_err), .buf_rbyte(buf_rbyte), .buf_idx(buf_idx), .buf_we(buf_we),
    .buf_wbyte(buf_wbyte), .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done),
    .sh_rx(sh_rx), .cs_n(spi_cs_n), .busy(busy_w), .done_flag(done_w),
    .err_flag(err_w), .cyc_finish(cyc_finish)
  );

  spi_byte_shift #(.DIV_HALF(DIV_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx)
  );
endmodule

// File: rtl/spi_menu_engine_chk.sv
module spi_menu_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic go_evt,
  input logic busy,
  input logic done_flag,
  input logic err_flag,
  input logic cyc_finish,
  input logic cs_n,
  input logic sck
);
  a_r7_go_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go_evt && !busy |=> busy);

  a_r7_finish_done: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_finish |=> (!busy && done_flag));

  a_r9_go_busy_err: assert property (@(posedge clk) disable iff (!rst_n)
    go_evt && busy |=> (err_flag && busy));

  a_r10_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r10_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
endmodule

bind spi_menu_engine spi_menu_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go_evt(go_evt), .busy(busy_w), .done_flag(done_w),
  .err_flag(err_w), .cyc_finish(cyc_finish), .cs_n(spi_cs_n), .sck(spi_sck)
);

// File: tb/spi_menu_engine_test.sv
module spi_menu_engine_test;
  localparam int DIVH = 2;
  localparam int GAP  = 4 * DIVH;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, miso;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire sck, cs_n, mosi;

  always #4 clk = ~clk;

  spi_menu_engine #(.DIV_HALF(DIVH), .BUF_BYTES(64)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int i);
    return 8'hC3 ^ 8'(i * 29);
  endfunction

  // behavioural flash: logs MOSI bytes per frame, replies with resp(byte index)
  int bc = 0, cur = 0, gapc = 0;
  bit inf = 0, seen = 0;
  logic [7:0] shr = '0, rb;
  logic [7:0] got[$];
  int lens[$];
  logic [7:0] eb[$];
  int el[$];

  always @* begin
    rb   = resp(bc / 8);
    miso = rb[7 - (bc % 8)];
  end
  always @(negedge cs_n) begin
    if (seen) chk(gapc >= GAP, "R10 chip-select gap", gapc, GAP);
    bc = 0; cur = 0; inf = 1; seen = 1;
  end
  always @(posedge cs_n) if (inf) begin lens.push_back(cur); inf = 0; gapc = 0; end
  always @(negedge clk) if (cs_n) gapc++;
  always @(posedge sck) if (!cs_n) begin
    shr = {shr[6:0], mosi}; bc++;
    if (bc % 8 == 0) begin got.push_back(shr); cur++; end
  end
  always @(negedge clk) if (rst_n) chk(!(cs_n && sck), "R10 sck low while deselected", sck, 0);

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    int n = 0;
    do begin rd(5'd18, s); n++; end while (!s[2] && n < 20000);
    chk(s[2], "R7 done reported", s, 4);
    chk(!s[0], "R7 busy cleared with done", s[0], 0);
  endtask

  function automatic logic [31:0] ctl(input int slot, input int n, input bit dph,
                                     input bit atom, input bit psel);
    return (32'(dph) << 14) | (32'((n - 1) & 63) << 8) | (32'(slot) << 4)
         | (32'(psel) << 3) | (32'(atom) << 2) | 32'h2;
  endfunction

  task automatic run(input logic [31:0] c);
    wr(5'd18, 32'hC);
    wr(5'd17, c);
    wait_done();
  endtask

  task automatic cmp_frames(input string req);
    chk(lens.size() == el.size(), {req, " frame count"}, lens.size(), el.size());
    for (int i = 0; i < el.size() && i < lens.size(); i++)
      chk(lens[i] == el[i], {req, " frame length"}, lens[i], el[i]);
    chk(got.size() == eb.size(), {req, " byte count"}, got.size(), eb.size());
    for (int i = 0; i < eb.size() && i < got.size(); i++)
      chk(got[i] == eb[i], {req, " frame byte"}, got[i], eb[i]);
    got.delete(); lens.delete(); eb.delete(); el.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] opc[8];
    int kd[8];
    logic [31:0] lo, hi, ty;
    opc = '{8'h02, 8'h03, 8'hD8, 8'h9F, 8'h06, 8'h05, 8'h0B, 8'hC7};
    kd  = '{3, 2, 3, 0, 1, 0, 2, 1};
    lo = '0; hi = '0; ty = '0;
    for (int i = 0; i < 4; i++) begin
      lo |= 32'(opc[i]) << (8 * i);
      hi |= 32'(opc[i + 4]) << (8 * i);
    end
    for (int i = 0; i < 8; i++) ty |= 32'(kd[i]) << (2 * i);

    repeat (3) @(negedge clk);
    rd(5'd18, v);
    chk(v == 0, "R11 status in reset", v, 0);
    chk(cs_n == 1'b1 && sck == 1'b0, "R11 pins in reset", {cs_n, sck}, 2);
    rst_n = 1'b1;
    rd(5'd18, v);
    chk(v == 0, "R11 status after reset", v, 0);

    wr(5'd19, lo); wr(5'd20, hi); wr(5'd21, ty); wr(5'd22, 32'h5006);
    wr(5'd16, 32'hAB123456);
    rd(5'd16, v);
    chk(v == 32'h00123456, "R2 upper address bits dropped", v, 32'h123456);

    // R1 R2 R4: addressed read of 5 bytes
    run(ctl(1, 5, 1, 0, 0));
    eb = '{8'h03, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    el = '{9};
    cmp_frames("R1 R2 R4 addressed read");
    rd(5'd0, v);
    chk(v == {resp(7), resp(6), resp(5), resp(4)}, "R4 read bytes in word 0", v,
        {resp(7), resp(6), resp(5), resp(4)});
    rd(5'd1, v);
    chk(v == {24'h0, resp(8)}, "R4 fifth read byte in word 1 lane 0", v, {24'h0, resp(8)});

    // R3 R6: atomic write with prefix 0
    wr(5'd0, 32'h44332211); wr(5'd1, 32'h88776655); wr(5'd16, 32'h00000100);
    run(ctl(0, 6, 1, 1, 0));
    eb = '{8'h06, 8'h02, 8'h00, 8'h01, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    el = '{1, 10};
    cmp_frames("R3 R6 atomic write prefix 0");

    // R5: phase disabled, large count field
    run(ctl(2, 21, 0, 0, 0));
    eb = '{8'hD8, 8'h00, 8'h01, 8'h00};
    el = '{4};
    cmp_frames("R5 data phase off");

    // R6 R4 R1: atomic unaddressed read with prefix 1
    run(ctl(3, 3, 1, 1, 1));
    eb = '{8'h50, 8'h9F, 8'h00, 8'h00, 8'h00};
    el = '{1, 4};
    cmp_frames("R6 R1 prefix 1 unaddressed read");
    rd(5'd0, v);
    chk(v == {8'h44, resp(3), resp(2), resp(1)}, "R4 partial word update", v,
        {8'h44, resp(3), resp(2), resp(1)});

    // R7 R9 R8: go while busy, then clears
    wr(5'd18, 32'hC);
    wr(5'd17, ctl(4, 1, 0, 0, 0));
    rd(5'd18, v);
    chk(v[0], "R7 busy after go", v, 1);
    wr(5'd17, ctl(7, 1, 0, 0, 0));
    rd(5'd18, v);
    chk(v[3] && v[0], "R9 error on go while busy", v, 9);
    wait_done();
    eb = '{8'h06};
    el = '{1};
    cmp_frames("R9 second go ignored");
    rd(5'd18, v);
    chk(v == 32'hC, "R8 done and error both set", v, 32'hC);
    wr(5'd18, 32'h0);
    rd(5'd18, v);
    chk(v == 32'hC, "R8 writing zeros keeps flags", v, 32'hC);
    wr(5'd18, 32'h4);
    rd(5'd18, v);
    chk(v == 32'h8, "R8 done cleared alone", v, 32'h8);
    wr(5'd18, 32'h8);
    rd(5'd18, v);
    chk(v == 32'h0, "R8 error cleared", v, 0);

    // R5 R4: full 64-byte read
    run(ctl(6, 64, 1, 0, 0));
    chk(lens.size() == 1 && lens[0] == 68, "R5 64-byte frame length",
        lens.size() == 1 ? lens[0] : -1, 68);
    got.delete(); lens.delete();
    rd(5'd0, v);
    chk(v[7:0] == resp(4), "R4 first byte of full read", v[7:0], resp(4));
    rd(5'd15, v);
    chk(v[31:24] == resp(67), "R3 R4 byte 63 in top lane of word 15", v[31:24], resp(67));

    repeat (20) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule